// File: doc/BRIEF.md
# Nibble-Loaded Auto-Reload Timer

This block is an 8-bit up-counter that sits on a 4-bit register bus. Software writes an 8-bit reload value as two nibbles: the high nibble first, then the low nibble. The second write moves both halves into the reload latch together. When the counter passes its maximum value, it takes the latch value, not zero. At the same moment it raises a sticky request flag. That flag drives an interrupt line gated by an enable bit, and an ungated pending line that a halted core can use to wake up.

The counter advances on one of two sources. The first is a tick from an internal prescaler that divides the clock by 2048, 512 or 128. The second is an edge on an external event pin, which passes through two synchronizer flip-flops first; software chooses the active edge. Four nibble addresses cover the whole interface:

- control flags at address 0
- prescaler field at address 1
- low and high count nibbles at addresses 2 and 3

Top module: `nib_reload_timer`

## Requirements
- R1: After reset, reads of addresses 0, 1, 2 and 3 all return 0, and `irq_o` and `pend_o` are low.
- R2: Each advance event adds exactly one to the count. A read of address 2 returns the live count bits 3:0, and a read of address 3 returns bits 7:4.
- R3: An advance event while the count is 8'hFF loads the count from the reload latch and sets the request flag.
- R4: A write to address 3 only stages a high nibble. A write to address 2 loads the reload latch with {staged high nibble, written low nibble}. A high-nibble write that is not followed by a low-nibble write leaves the latch unchanged.
- R5: The prescaler field is address 1, bits 2:0. Value 0 gives one count per 2048 clocks, 1 gives one per 512, and 2 through 7 give one per 128. A write to address 1 restarts the prescaler, so the first increment lands on the N-th rising edge after the write edge.
- R6: Control bit 1 selects the source: 0 is the prescaler, 1 is the event pin. Advance events from the source that is not selected do not change the count.
- R7: Control bit 0 selects the active edge of `ev_i`: 0 is rising, 1 is falling. The opposite edge has no effect. The count changes on the third rising clock edge after `ev_i` changes.
- R8: The request flag reads back as control bit 3. It stays set until software writes 0 to bit 3. Writing 1 to bit 3 never sets it. If an overflow happens in the same cycle as a clear, the flag ends up set.
- R9: `irq_o` is the request flag ANDed with control bit 2, the enable bit. `pend_o` is the request flag whatever the enable bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register nibble address |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Read data nibble for `addr_i` |
| ev_i | input | 1 | External event input, asynchronous |
| irq_o | output | 1 | Interrupt request, gated by the enable bit |
| pend_o | output | 1 | Ungated request flag for wake-up |

## Verification
The bench checks the write order. A high-nibble write on its own must leave the latch alone; a design that loads each nibble straight into the latch would reload a mixed value. It runs a table of reload values, including 8'hFF, which must overflow again on the very next event. For each value it counts the events needed to reach the next overflow; a design that reloads zero, or is off by one in the wrap, gives a different count. It also checks, edge by edge:

- the three-edge latency through the event synchronizer
- that the wrong edge of `ev_i` is ignored
- the exact prescaler periods for all three ratios, where a prescaler that is not restarted or is off by one moves the increment a cycle
- the write-one-does-not-set rule on the flag

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_MODE   = 2'd1,
    A_CNT_LO = 2'd2,
    A_CNT_HI = 2'd3
  } tmr_addr_e;

  localparam int CB_FALL  = 0;
  localparam int CB_EXT   = 1;
  localparam int CB_IE    = 2;
  localparam int CB_FLAG  = 3;
  localparam int MODE_W   = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int LOG0 = 11,
  parameter int LOG1 = 9,
  parameter int LOG2 = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PW = LOG0;

  logic [PW-1:0] cnt, lim;

  always_comb begin
    case (sel_i)
      SEL_W'(0): lim = PW'((32'd1 << LOG0) - 32'd1);
      SEL_W'(1): lim = PW'((32'd1 << LOG1) - 32'd1);
      default:   lim = PW'((32'd1 << LOG2) - 32'd1);
    endcase
  end

  assign tick_o = (cnt == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt <= '0;
    else if (clr_i || tick_o) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R5: divider phase never runs past the selected limit
  a_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= lim);
  // R5: a restart request puts the phase back at zero
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt == '0) && !tick_o);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic fall_sel_i,
  output logic pulse_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], ev_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign rise    = sync_q[SYNC-1] & ~prev_q;
  assign fall    = ~sync_q[SYNC-1] & prev_q;
  assign pulse_o = fall_sel_i ? fall : rise;

  // R7: one edge yields one pulse unless the edge selection moved
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o || (fall_sel_i != $past(fall_sel_i)));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          hi_we_i,
  input  logic          lo_we_i,
  input  logic [NW-1:0] wdata_i,
  input  logic          flag_clr_i,
  output logic [2*NW-1:0] cnt_o,
  output logic          flag_o
);
  localparam int CW = 2 * NW;

  logic [NW-1:0] hi_stage;
  logic [CW-1:0] latch, cnt;
  logic          flag, ovf;

  assign ovf = inc_i && (cnt == {CW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_stage <= '0;
      latch    <= '0;
      cnt      <= '0;
      flag     <= 1'b0;
    end else begin
      if (hi_we_i) hi_stage <= wdata_i;
      if (lo_we_i) latch <= {hi_stage, wdata_i};
      if (ovf)        cnt <= latch;
      else if (inc_i) cnt <= cnt + 1'b1;
      if (ovf)             flag <= 1'b1;
      else if (flag_clr_i) flag <= 1'b0;
    end
  end

  assign cnt_o  = cnt;
  assign flag_o = flag;

  // R3: wrap reloads from the latch and raises the flag
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> (cnt == $past(latch)) && flag);
  // R2: ordinary advance steps by one
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !ovf |=> cnt == $past(cnt) + 1'b1);
  // R4: latch only moves on a low-nibble write
  a_r4_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_we_i |=> $stable(latch));
  // R8: set wins over a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf && flag_clr_i |=> flag);
  // R8: flag is sticky without a clear
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !flag_clr_i |=> flag);
endmodule

// File: rtl/nib_reload_timer.sv
module nib_reload_timer #(
  parameter int NIB_W       = 4,
  parameter int PRE_LOG0    = 11,
  parameter int PRE_LOG1    = 9,
  parameter int PRE_LOG2    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  output logic [NIB_W-1:0] rdata_o,
  input  logic             ev_i,
  output logic             irq_o,
  output logic             pend_o
);
  import tmr_pkg::*;

  localparam int CW = 2 * NIB_W;

  tmr_addr_e          addr;
  logic               fall_sel, ext_sel, ie;
  logic [MODE_W-1:0]  mode_sel;
  logic               ctrl_we, mode_we, lo_we, hi_we, flag_clr;
  logic               pre_tick, ev_pulse, inc, flag;
  logic [CW-1:0]      cnt;
  logic [NIB_W-1:0]   ctrl_rd;

  assign addr     = tmr_addr_e'(addr_i);
  assign ctrl_we  = we_i && (addr == A_CTRL);
  assign mode_we  = we_i && (addr == A_MODE);
  assign lo_we    = we_i && (addr == A_CNT_LO);
  assign hi_we    = we_i && (addr == A_CNT_HI);
  assign flag_clr = ctrl_we && !wdata_i[CB_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_sel <= 1'b0;
      ext_sel  <= 1'b0;
      ie       <= 1'b0;
      mode_sel <= '0;
    end else begin
      if (ctrl_we) begin
        fall_sel <= wdata_i[CB_FALL];
        ext_sel  <= wdata_i[CB_EXT];
        ie       <= wdata_i[CB_IE];
      end
      if (mode_we) mode_sel <= wdata_i[MODE_W-1:0];
    end
  end

  tmr_prescale #(
    .LOG0(PRE_LOG0), .LOG1(PRE_LOG1), .LOG2(PRE_LOG2), .SEL_W(MODE_W)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_we),
    .sel_i(mode_sel), .tick_o(pre_tick)
  );

  tmr_edge_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev_i),
    .fall_sel_i(fall_sel), .pulse_o(ev_pulse)
  );

  assign inc = ext_sel ? ev_pulse : pre_tick;

  tmr_count_core #(.NW(NIB_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc),
    .hi_we_i(hi_we), .lo_we_i(lo_we), .wdata_i(wdata_i),
    .flag_clr_i(flag_clr), .cnt_o(cnt), .flag_o(flag)
  );

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_FALL] = fall_sel;
    ctrl_rd[CB_EXT]  = ext_sel;
    ctrl_rd[CB_IE]   = ie;
    ctrl_rd[CB_FLAG] = flag;
  end

  always_comb begin
    case (addr)
      A_CTRL:   rdata_o = ctrl_rd;
      A_MODE:   rdata_o = NIB_W'(mode_sel);
      A_CNT_LO: rdata_o = cnt[NIB_W-1:0];
      default:  rdata_o = cnt[CW-1:NIB_W];
    endcase
  end

  assign irq_o  = flag & ie;
  assign pend_o = flag;

  // R6: with the prescaler selected, event pulses leave the count alone
  a_r6_pre_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sel && !pre_tick |=> $stable(cnt));
  // R6: with the event pin selected, prescaler ticks leave the count alone
  a_r6_ev_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel && !ev_pulse |=> $stable(cnt));
  // R8: a clear without a wrap drops the pending line
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr && !inc |=> !pend_o);
  // R9: interrupt never asserts without pending
  a_r9_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o);
endmodule

// File: tb/nib_reload_timer_test.sv
module nib_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [3:0] wdata_i = 4'd0;
  logic [3:0] rdata_o;
  logic       ev_i = 1'b0;
  logic       irq_o, pend_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  localparam int NVEC = 5;
  localparam logic [7:0] RELOAD_VEC [NVEC] = '{8'hF0, 8'hFE, 8'h3C, 8'hFF, 8'hA5};

  nib_reload_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ev_i(ev_i),
    .irq_o(irq_o), .pend_o(pend_o)
  );

  always #5ns clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    addr_i = a;
    #1ns d = rdata_o;
  endtask

  task automatic rd_cnt(output logic [7:0] c);
    logic [3:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    c = {hi, lo};
  endtask

  task automatic ev_set(input logic v);
    @(negedge clk);
    ev_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse();
    ev_set(1'b1);
    ev_set(1'b0);
  endtask

  task automatic prescale_case(input logic [2:0] fld, input int ratio, input string tag);
    logic [7:0] base, now;
    wr(2'd1, {1'b0, fld});
    rd_cnt(base);
    repeat (ratio - 1) @(negedge clk);
    rd_cnt(now);
    chk({tag, " no step before period"}, now, base);
    @(negedge clk);
    rd_cnt(now);
    chk({tag, " step at period"}, now, 8'(base + 8'd1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] d;
    logic [7:0] c, c0;
    int         prev;
    int         n;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk($sformatf("R1 reset read addr %0d", a), d, 0);
    end
    chk("R1 reset irq_o", irq_o, 0);
    chk("R1 reset pend_o", pend_o, 0);

    // Table walk: external source, rising edge; R3 R4 R2
    wr(2'd0, 4'b0010);
    prev = 0;
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd3, RELOAD_VEC[i][7:4]);
      wr(2'd2, RELOAD_VEC[i][3:0]);
      n = 0;
      while (!pend_o && n < 300) begin
        pulse();
        n++;
      end
      chk($sformatf("R3 events to wrap vec %0d", i), n, 256 - prev);
      rd_cnt(c);
      chk($sformatf("R4 reloaded count vec %0d", i), c, RELOAD_VEC[i]);
      wr(2'd0, 4'b0010);
      chk($sformatf("R8 cleared vec %0d", i), pend_o, 0);
      prev = RELOAD_VEC[i];
    end

    // R4 high-nibble write alone leaves the latch
    wr(2'd3, 4'h1);
    for (int k = 0; k < 256 - 8'hA5; k++) pulse();
    rd_cnt(c);
    chk("R4 high-only write ignored", c, 8'hA5);
    chk("R3 flag raised", pend_o, 1);

    // R9 / R8 flag behaviour
    repeat (20) @(negedge clk);
    chk("R8 flag sticky", pend_o, 1);
    chk("R9 irq gated off", irq_o, 0);
    wr(2'd0, 4'b1110);
    chk("R9 irq with enable", irq_o, 1);
    chk("R9 pend with enable", pend_o, 1);
    wr(2'd0, 4'b0110);
    chk("R8 write 0 clears", pend_o, 0);
    wr(2'd0, 4'b1110);
    chk("R8 write 1 does not set", pend_o, 0);
    rd(2'd0, d);
    chk("R8 ctrl readback", d, 4'b0110);

    // R7 falling edge and latency; R2 single step
    wr(2'd0, 4'b0011);
    rd_cnt(c0);
    ev_set(1'b1);
    @(negedge clk);
    rd_cnt(c);
    chk("R7 rising ignored in falling mode", c, c0);
    @(negedge clk);
    ev_i = 1'b0;
    repeat (2) @(negedge clk);
    rd_cnt(c);
    chk("R7 no change before third edge", c, c0);
    @(negedge clk);
    rd_cnt(c);
    chk("R7 falling step on third edge", c, 8'(c0 + 8'd1));
    wr(2'd0, 4'b0010);
    @(negedge clk);
    ev_i = 1'b1;
    repeat (2) @(negedge clk);
    rd_cnt(c);
    chk("R7 rising not yet", c, 8'(c0 + 8'd1));
    @(negedge clk);
    rd_cnt(c);
    chk("R2 rising step by one", c, 8'(c0 + 8'd2));
    ev_set(1'b0);
    rd_cnt(c);
    chk("R7 falling ignored in rising mode", c, 8'(c0 + 8'd2));

    // R6 prescaler ignored while external selected
    wr(2'd1, 4'd2);
    rd_cnt(c0);
    repeat (300) @(negedge clk);
    rd_cnt(c);
    chk("R6 prescaler ignored on ext", c, c0);

    // R6 events ignored while prescaler selected
    wr(2'd0, 4'b0000);
    wr(2'd1, 4'd0);
    rd_cnt(c0);
    pulse();
    rd_cnt(c);
    chk("R6 event ignored on prescaler", c, c0);

    // R5 ratios
    prescale_case(3'd0, 2048, "R5 div2048");
    prescale_case(3'd1, 512, "R5 div512");
    prescale_case(3'd2, 128, "R5 div128");
    prescale_case(3'd6, 128, "R5 field6 div128");
    rd(2'd1, d);
    chk("R5 mode readback", d, 4'd6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule